// File: doc/BRIEF.md
# Enable-Triggered Arithmetic Core

This core is one compute cell of a statically configured reconfigurable array. Its configuration (opcode, six source selectors, init controls and eight 16-bit constants) is held steady on input ports while it runs. Each cycle it gathers a data bus from the incoming channels, the constants and its own first result, and a one-bit enable bus from the channel enable bits and its own two output enable bits. It does nothing until the enable bit picked by its enable selector is high; in that cycle it performs its opcode and registers the result.

Each output is a 16-bit data word plus a one-bit enable. Downstream cells use the enable as their trigger, so results flow through a graph of cores without tokens or a central sequencer. Compare opcodes raise the first output's enable only when the condition holds, which lets a branch of the graph fire conditionally. A loop opcode turns the core into an index generator that ends with a one-cycle exit pulse. A separate init source can preset the first output. This seeds running reductions such as a running minimum that feeds its own result back.

Top module: `trig_alu_core`

## Requirements
- R1: A 5-bit selector picks a data source by index: 0..11 are the channels, 12..19 are the constants 0..7, 20 is the core's own registered first-output data, and every other index reads zero. Enable and init selectors pick an enable source: 0..11 are the channel enable bits, 12 is the first-output enable, 13 is the second-output enable, and any other index reads zero.
- R2: Results appear one cycle after the edge on which the selected enable bit was high. Both output enable bits are single-cycle pulses and are low in every other cycle. The data words hold their value when nothing updates them.
- R3: Opcode 0x01 (A+B) and opcode 0x02 (A-B) wrap modulo 2^16 into the first output. The second output carries the unsigned carry (for add) or the borrow, set when A<B unsigned (for subtract), in bit 0. Both enables pulse.
- R4: Opcode 0x03 places the signed minimum of A and B on the first output, and opcode 0x04 the signed maximum. The second output is untouched. Selecting index 20 as A forms a running reduction.
- R5: Opcodes 0x10 (A>B), 0x11 (A>=B), 0x12 (A<B), 0x13 (A<=B), 0x14 (A==B) and 0x15 (A!=B) compare A and B as signed values. The second output always gets C when the condition holds and D otherwise, with its enable pulsed. The first output's enable pulses, with data C, only when the condition holds.
- R6: Opcode 0x20 is a loop. A is the start, B the exclusive signed end, C the step and D the gap. The start index appears one cycle after the trigger if start<end. Each later index (previous+step) appears D+1 cycles after the one before, as long as it stays below the end.
- R7: A loop raises the second-output enable for exactly one cycle when it ends. This happens D+1 cycles after its last index, or one cycle after the trigger when start>=end.
- R8: Triggers that arrive while a loop is running are ignored. A trigger in the cycle the exit pulse is visible starts a new loop.
- R9: With the init-use flag set and the selected init bit high, the first output's data loads the preset next cycle and its enable stays low. The preset is the constant init value when the init-kind flag is 0, or operand B when it is 1. This overrides any result for the first output in that cycle. With the flag clear, the init bit has no effect.
- R10: After reset both data words and both enables are zero and no loop is running.
- R11: Any opcode not listed above produces no output activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_data | input | 192 | Twelve 16-bit incoming channel words, channel i at bits 16i+15:16i |
| ch_ee | input | 12 | Enable bit of each incoming channel |
| cfg_opcode | input | 8 | Operation code |
| cfg_sel_a | input | 5 | Source index of operand A |
| cfg_sel_b | input | 5 | Source index of operand B |
| cfg_sel_c | input | 5 | Source index of operand C |
| cfg_sel_d | input | 5 | Source index of operand D |
| cfg_sel_en | input | 5 | Enable-bus index of the trigger |
| cfg_sel_init | input | 5 | Enable-bus index of the init strobe |
| cfg_init_use | input | 1 | Init strobe is honoured when 1 |
| cfg_init_kind | input | 1 | Preset source: 0 constant value, 1 operand B |
| cfg_init_val | input | 16 | Constant preset value |
| cfg_consts | input | 128 | Eight 16-bit constants, constant k at bits 16k+15:16k |
| out1_data | output | 16 | First output data |
| out1_ee | output | 1 | First output enable |
| out2_data | output | 16 | Second output data |
| out2_ee | output | 1 | Second output enable |

## Verification
On every cycle the assertions check four things. No enable pulse appears without a trigger or a running loop. An init strobe always yields the preset with the enable low. A triggered compare always answers on the second output, and its first output agrees with it. A loop ending always coincides with the exit pulse. The arithmetic values, signed orderings, source indexing and the exact spacing of loop indices under a gap can only be shown by the bench's scenarios against its reference model. The same holds for ignoring retriggers and for the init-use flag.

// File: rtl/trig_alu_pkg.sv
package trig_alu_pkg;

   typedef enum logic [7:0] {
      OP_NOP  = 8'h00,
      OP_ADD  = 8'h01,
      OP_SUB  = 8'h02,
      OP_MIN  = 8'h03,
      OP_MAX  = 8'h04,
      OP_GT   = 8'h10,
      OP_GE   = 8'h11,
      OP_LT   = 8'h12,
      OP_LE   = 8'h13,
      OP_EQ   = 8'h14,
      OP_NE   = 8'h15,
      OP_LOOP = 8'h20
   } opcode_e;

   // what a single-cycle instruction does to the two outputs
   typedef struct packed {
      logic upd1;
      logic ee1;
      logic upd2;
      logic ee2;
   } effect_t;

   function automatic logic op_is_cmp(input logic [7:0] op);
      return (op >= OP_GT) && (op <= OP_NE);
   endfunction

endpackage

// File: rtl/trig_alu_opsel.sv
module trig_alu_opsel #(
   parameter int DW   = 16,
   parameter int SELW = 5,
   localparam int NSRC = 2 ** SELW
) (
   input  logic [NSRC*DW-1:0] bus,
   input  logic [SELW-1:0]    sel,
   output logic [DW-1:0]      q
);

   always_comb begin
      q = '0;
      for (int i = 0; i < NSRC; i++) begin
         if (sel == SELW'(i)) q = bus[i*DW +: DW];
      end
   end

endmodule

// File: rtl/trig_alu_exec.sv
module trig_alu_exec
   import trig_alu_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic [7:0]    op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   input  logic [DW-1:0] c,
   input  logic [DW-1:0] d,
   output logic [DW-1:0] res1,
   output logic [DW-1:0] res2,
   output effect_t       fx
);

   logic [DW:0] sum_w, dif_w;
   logic        a_gt, a_eq, cond;

   assign sum_w = {1'b0, a} + {1'b0, b};
   assign dif_w = {1'b0, a} - {1'b0, b};
   assign a_gt  = $signed(a) > $signed(b);
   assign a_eq  = (a == b);

   always_comb begin
      unique case (op)
         OP_GT:   cond = a_gt;
         OP_GE:   cond = a_gt | a_eq;
         OP_LT:   cond = ~(a_gt | a_eq);
         OP_LE:   cond = ~a_gt;
         OP_EQ:   cond = a_eq;
         OP_NE:   cond = ~a_eq;
         default: cond = 1'b0;
      endcase
   end

   always_comb begin
      res1 = '0;
      res2 = '0;
      fx   = '0;
      if (op == OP_ADD) begin
         res1 = sum_w[DW-1:0];
         res2 = DW'(sum_w[DW]);
         fx   = '{upd1: 1'b1, ee1: 1'b1, upd2: 1'b1, ee2: 1'b1};
      end else if (op == OP_SUB) begin
         res1 = dif_w[DW-1:0];
         res2 = DW'(dif_w[DW]);
         fx   = '{upd1: 1'b1, ee1: 1'b1, upd2: 1'b1, ee2: 1'b1};
      end else if (op == OP_MIN || op == OP_MAX) begin
         res1 = ((op == OP_MAX) == a_gt) ? a : b;
         fx   = '{upd1: 1'b1, ee1: 1'b1, upd2: 1'b0, ee2: 1'b0};
      end else if (op_is_cmp(op)) begin
         res1 = c;
         res2 = cond ? c : d;
         fx   = '{upd1: cond, ee1: cond, upd2: 1'b1, ee2: 1'b1};
      end
   end

endmodule

// File: rtl/trig_alu_loop.sv
module trig_alu_loop #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [DW-1:0] start,
   input  logic [DW-1:0] stop,
   input  logic [DW-1:0] step,
   input  logic [DW-1:0] gap,
   output logic          emit,
   output logic [DW-1:0] emit_val,
   output logic          exit_now,
   output logic          running
);

   logic [DW-1:0]        cur;
   logic [DW-1:0]        wait_cnt;
   logic signed [DW:0]   nxt_w;
   logic                 first_ok, cont;

   // one extra bit so that a step past the top of the range never wraps back below the end
   assign nxt_w    = $signed({cur[DW-1], cur}) + $signed({step[DW-1], step});
   assign cont     = nxt_w < $signed({stop[DW-1], stop});
   assign first_ok = $signed(start) < $signed(stop);

   always_comb begin
      emit     = 1'b0;
      exit_now = 1'b0;
      emit_val = start;
      if (!running) begin
         if (go) begin
            emit     = first_ok;
            exit_now = ~first_ok;
         end
      end else if (wait_cnt == '0) begin
         if (cont) begin
            emit     = 1'b1;
            emit_val = nxt_w[DW-1:0];
         end else begin
            exit_now = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         cur      <= '0;
         wait_cnt <= '0;
      end else if (emit) begin
         running  <= 1'b1;
         cur      <= emit_val;
         wait_cnt <= gap;
      end else if (exit_now) begin
         running  <= 1'b0;
      end else if (running) begin
         wait_cnt <= wait_cnt - 1'b1;
      end
   end

endmodule

// File: rtl/trig_alu_core.sv
module trig_alu_core
   import trig_alu_pkg::*;
#(
   parameter int DW   = 16,
   parameter int NCH  = 12,
   parameter int NRF  = 8,
   parameter int SELW = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH*DW-1:0] ch_data,
   input  logic [NCH-1:0]    ch_ee,
   input  logic [7:0]        cfg_opcode,
   input  logic [SELW-1:0]   cfg_sel_a,
   input  logic [SELW-1:0]   cfg_sel_b,
   input  logic [SELW-1:0]   cfg_sel_c,
   input  logic [SELW-1:0]   cfg_sel_d,
   input  logic [SELW-1:0]   cfg_sel_en,
   input  logic [SELW-1:0]   cfg_sel_init,
   input  logic              cfg_init_use,
   input  logic              cfg_init_kind,
   input  logic [DW-1:0]     cfg_init_val,
   input  logic [NRF*DW-1:0] cfg_consts,
   output logic [DW-1:0]     out1_data,
   output logic              out1_ee,
   output logic [DW-1:0]     out2_data,
   output logic              out2_ee
);

   localparam int NSRC    = 2 ** SELW;
   localparam int SLOT_FB = NCH + NRF;   // own first-output data on the data bus
   localparam int EE_FB1  = NCH;         // own first-output enable on the enable bus
   localparam int EE_FB2  = NCH + 1;     // own second-output enable on the enable bus

   if (SLOT_FB + 1 > NSRC) begin : g_bad_dbus
      $error("data bus sources exceed selector range");
   end
   if (EE_FB2 + 1 > NSRC) begin : g_bad_ebus
      $error("enable bus sources exceed selector range");
   end
   if (DW < 2) begin : g_bad_dw
      $error("data width too small");
   end

   logic [NSRC*DW-1:0]         dbus;
   logic [NSRC-1:0]            ebus;
   logic [3:0][SELW-1:0]       opnd_sel;
   logic [3:0][DW-1:0]         opnd;
   logic                       fire, init_bit, init_hit, is_loop;
   logic [DW-1:0]              preset, res1, res2, lp_val;
   logic                       lp_emit, lp_exit, loop_busy;
   effect_t                    fx;

   for (genvar i = 0; i < NSRC; i++) begin : g_dbus
      if (i < NCH) begin : g_ch
         assign dbus[i*DW +: DW] = ch_data[i*DW +: DW];
      end else if (i < SLOT_FB) begin : g_rf
         assign dbus[i*DW +: DW] = cfg_consts[(i-NCH)*DW +: DW];
      end else if (i == SLOT_FB) begin : g_fb
         assign dbus[i*DW +: DW] = out1_data;
      end else begin : g_zero
         assign dbus[i*DW +: DW] = '0;
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_ebus
      if (i < NCH) begin : g_ch
         assign ebus[i] = ch_ee[i];
      end else if (i == EE_FB1) begin : g_fb1
         assign ebus[i] = out1_ee;
      end else if (i == EE_FB2) begin : g_fb2
         assign ebus[i] = out2_ee;
      end else begin : g_zero
         assign ebus[i] = 1'b0;
      end
   end

   assign opnd_sel = {cfg_sel_d, cfg_sel_c, cfg_sel_b, cfg_sel_a};

   for (genvar k = 0; k < 4; k++) begin : g_opnd
      trig_alu_opsel #(.DW(DW), .SELW(SELW)) u_sel (
         .bus (dbus),
         .sel (opnd_sel[k]),
         .q   (opnd[k])
      );
   end

   trig_alu_opsel #(.DW(1), .SELW(SELW)) u_en_sel (
      .bus (ebus),
      .sel (cfg_sel_en),
      .q   (fire)
   );

   trig_alu_opsel #(.DW(1), .SELW(SELW)) u_init_sel (
      .bus (ebus),
      .sel (cfg_sel_init),
      .q   (init_bit)
   );

   assign is_loop  = (cfg_opcode == OP_LOOP);
   assign init_hit = cfg_init_use & init_bit;
   assign preset   = cfg_init_kind ? opnd[1] : cfg_init_val;

   trig_alu_exec #(.DW(DW)) u_exec (
      .op   (cfg_opcode),
      .a    (opnd[0]),
      .b    (opnd[1]),
      .c    (opnd[2]),
      .d    (opnd[3]),
      .res1 (res1),
      .res2 (res2),
      .fx   (fx)
   );

   trig_alu_loop #(.DW(DW)) u_loop (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (fire & is_loop),
      .start    (opnd[0]),
      .stop     (opnd[1]),
      .step     (opnd[2]),
      .gap      (opnd[3]),
      .emit     (lp_emit),
      .emit_val (lp_val),
      .exit_now (lp_exit),
      .running  (loop_busy)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out1_data <= '0;
         out1_ee   <= 1'b0;
         out2_data <= '0;
         out2_ee   <= 1'b0;
      end else begin
         out1_ee <= 1'b0;
         out2_ee <= 1'b0;
         if (is_loop) begin
            if (lp_emit) begin
               out1_data <= lp_val;
               out1_ee   <= 1'b1;
            end
            if (lp_exit) out2_ee <= 1'b1;
         end else if (fire) begin
            if (fx.upd1) out1_data <= res1;
            if (fx.upd2) out2_data <= res2;
            out1_ee <= fx.ee1;
            out2_ee <= fx.ee2;
         end
         if (init_hit) begin
            out1_data <= preset;
            out1_ee   <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/trig_alu_chk.sv
module trig_alu_chk
   import trig_alu_pkg::*;
#(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          fire,
   input logic          init_hit,
   input logic          loop_busy,
   input logic [7:0]    cfg_opcode,
   input logic [DW-1:0] preset,
   input logic [DW-1:0] out1_data,
   input logic          out1_ee,
   input logic [DW-1:0] out2_data,
   input logic          out2_ee
);

   AST_PULSE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      (out1_ee || out2_ee) |-> $past(fire || loop_busy)); // R2

   AST_INIT_PRESET: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(init_hit)) |-> (out1_data == $past(preset) && !out1_ee)); // R9

   AST_CMP_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(fire) && op_is_cmp($past(cfg_opcode))) |-> out2_ee); // R5

   AST_CMP_SAME_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      (out1_ee && op_is_cmp($past(cfg_opcode))) |-> (out1_data == out2_data)); // R5

   AST_EXIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(loop_busy) |-> out2_ee); // R7

endmodule

bind trig_alu_core trig_alu_chk #(.DW(DW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fire       (fire),
   .init_hit   (init_hit),
   .loop_busy  (loop_busy),
   .cfg_opcode (cfg_opcode),
   .preset     (preset),
   .out1_data  (out1_data),
   .out1_ee    (out1_ee),
   .out2_data  (out2_data),
   .out2_ee    (out2_ee)
);

// File: tb/trig_alu_core_bench.sv
module trig_alu_core_bench;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW = 16, NCH = 12, NRF = 8, SELW = 5;
   localparam int LIMIT = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH*DW-1:0] ch_data = '0;
   logic [NCH-1:0]    ch_ee = '0;
   logic [7:0]        cfg_opcode = 8'h00;
   logic [SELW-1:0]   sel_a = '0, sel_b = 5'd1, sel_c = 5'd2, sel_d = 5'd3;
   logic [SELW-1:0]   sel_en = 5'd5, sel_init = 5'd6;
   logic              init_use = 1'b0, init_kind = 1'b0;
   logic [DW-1:0]     init_val = '0;
   logic [NRF*DW-1:0] consts = '0;
   logic [DW-1:0]     out1_data, out2_data;
   logic              out1_ee, out2_ee;

   int    checks = 0, fails = 0;
   string cur_req = "R10";
   bit    cmp_on = 1'b0;

   // reference state
   logic [15:0] m_o1d = '0, m_o2d = '0;
   logic        m_o1e = 1'b0, m_o2e = 1'b0;
   bit          m_run = 1'b0;
   int          m_cur = 0, m_wait = 0;

   always #2.5 clk = ~clk;

   trig_alu_core u_trig_alu_core (
      .clk(clk), .rst_n(rst_n), .ch_data(ch_data), .ch_ee(ch_ee),
      .cfg_opcode(cfg_opcode), .cfg_sel_a(sel_a), .cfg_sel_b(sel_b),
      .cfg_sel_c(sel_c), .cfg_sel_d(sel_d), .cfg_sel_en(sel_en),
      .cfg_sel_init(sel_init), .cfg_init_use(init_use), .cfg_init_kind(init_kind),
      .cfg_init_val(init_val), .cfg_consts(consts),
      .out1_data(out1_data), .out1_ee(out1_ee), .out2_data(out2_data), .out2_ee(out2_ee)
   );

   function automatic logic [15:0] pick(input int s);
      if (s < NCH) return ch_data[s*16 +: 16];
      if (s < NCH + NRF) return consts[(s-NCH)*16 +: 16];
      if (s == NCH + NRF) return m_o1d;
      return 16'h0;
   endfunction

   function automatic logic pick_ee(input int s);
      if (s < NCH) return ch_ee[s];
      if (s == NCH) return m_o1e;
      if (s == NCH + 1) return m_o2e;
      return 1'b0;
   endfunction

   function automatic int sx(input logic [15:0] v);
      return int'($signed(v));
   endfunction

   function automatic bit holds(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
      case (op)
         8'h10: return sx(a) >  sx(b);
         8'h11: return sx(a) >= sx(b);
         8'h12: return sx(a) <  sx(b);
         8'h13: return sx(a) <= sx(b);
         8'h14: return a == b;
         8'h15: return a != b;
         default: return 1'b0;
      endcase
   endfunction

   always @(posedge clk) begin : model
      logic [15:0] a, b, c, d, n1d, n2d;
      logic        n1e, n2e, en;
      int          nx;
      if (!rst_n) begin
         m_o1d = '0; m_o2d = '0; m_o1e = 0; m_o2e = 0; m_run = 0; m_cur = 0; m_wait = 0;
      end else begin
         a = pick(int'(sel_a)); b = pick(int'(sel_b));
         c = pick(int'(sel_c)); d = pick(int'(sel_d));
         en = pick_ee(int'(sel_en));
         n1d = m_o1d; n2d = m_o2d; n1e = 0; n2e = 0;
         if (cfg_opcode == 8'h20) begin
            if (!m_run) begin
               if (en) begin
                  if (sx(a) < sx(b)) begin
                     n1d = a; n1e = 1; m_cur = sx(a); m_wait = int'(d); m_run = 1;
                  end else n2e = 1;
               end
            end else if (m_wait > 0) begin
               m_wait = m_wait - 1;
            end else begin
               nx = m_cur + sx(c);
               if (nx < sx(b)) begin
                  n1d = nx[15:0]; n1e = 1; m_cur = sx(nx[15:0]); m_wait = int'(d);
               end else begin
                  n2e = 1; m_run = 0;
               end
            end
         end else if (en) begin
            case (cfg_opcode)
               8'h01: begin n1d = a + b; n2d = {15'b0, (int'(a) + int'(b)) > 65535}; n1e = 1; n2e = 1; end
               8'h02: begin n1d = a - b; n2d = {15'b0, a < b}; n1e = 1; n2e = 1; end
               8'h03: begin n1d = (sx(a) < sx(b)) ? a : b; n1e = 1; end
               8'h04: begin n1d = (sx(a) > sx(b)) ? a : b; n1e = 1; end
               8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15: begin
                  n2e = 1;
                  n2d = holds(cfg_opcode, a, b) ? c : d;
                  if (holds(cfg_opcode, a, b)) begin n1d = c; n1e = 1; end
               end
               default: ;
            endcase
         end
         if (init_use && pick_ee(int'(sel_init))) begin
            n1d = init_kind ? b : init_val; n1e = 0;
         end
         m_o1d = n1d; m_o1e = n1e; m_o2d = n2d; m_o2e = n2e;
      end
   end

   task automatic check(input string r, input logic [33:0] got, input logic [33:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", r, got, exp);
      end
   endtask

   always @(negedge clk) begin
      if (cmp_on) check(cur_req, {out1_data, out1_ee, out2_data, out2_ee}, {m_o1d, m_o1e, m_o2d, m_o2e});
   end

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic fire1();
      ch_ee[5] = 1'b1;
      step();
      ch_ee[5] = 1'b0;
   endtask

   task automatic setch(input int i, input logic [15:0] v);
      ch_data[i*16 +: 16] = v;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      fails++;
      $display("FAIL R2: watchdog actual hung expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [7:0]  ops [12];
      logic [15:0] prev;
      ops = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h10, 8'h11, 8'h12, 8'h13, 8'h14, 8'h15, 8'h20};
      repeat (3) step();
      check("R10", {out1_data, out1_ee, out2_data, out2_ee}, 34'h0);
      rst_n = 1'b1;
      cmp_on = 1'b1;
      step();

      // R3 add and subtract
      cur_req = "R3"; cfg_opcode = 8'h01;
      setch(0, 16'hFFFF); setch(1, 16'h0002);
      fire1();
      check("R3", {out1_data, out1_ee, out2_data, out2_ee}, {16'h0001, 1'b1, 16'h0001, 1'b1});
      step();
      check("R2", {17'b0, out1_data, out1_ee}, {17'b0, 16'h0001, 1'b0});
      cfg_opcode = 8'h02; setch(0, 16'h0003); setch(1, 16'h0005);
      fire1();
      check("R3", {out1_data, out1_ee, out2_data, out2_ee}, {16'hFFFE, 1'b1, 16'h0001, 1'b1});
      setch(0, 16'h0005); setch(1, 16'h0003);
      fire1();
      check("R3", {out1_data, out1_ee, out2_data, out2_ee}, {16'h0002, 1'b1, 16'h0000, 1'b1});

      // R1 source indexing
      cur_req = "R1"; cfg_opcode = 8'h01;
      consts[3*16 +: 16] = 16'd100; sel_b = 5'd15; setch(0, 16'd3);
      fire1();
      check("R1", {18'b0, out1_data}, {18'b0, 16'd103});
      sel_a = 5'd25; sel_b = 5'd0; setch(0, 16'd9);
      fire1();
      check("R1", {18'b0, out1_data}, {18'b0, 16'd9});
      sel_en = 5'd30; ch_ee = '1;
      step(); step();
      check("R2", {17'b0, out1_data, out1_ee}, {17'b0, 16'd9, 1'b0});
      ch_ee = '0; sel_en = 5'd5; sel_a = 5'd0; sel_b = 5'd1;

      // R4 running minimum seeded by init, R9
      cur_req = "R4"; cfg_opcode = 8'h03; sel_a = 5'd20; sel_b = 5'd0;
      init_use = 1'b1; init_kind = 1'b0; init_val = 16'h7FFF;
      ch_ee[6] = 1'b1; step(); ch_ee[6] = 1'b0;
      check("R9", {17'b0, out1_data, out1_ee}, {17'b0, 16'h7FFF, 1'b0});
      setch(0, 16'd50); fire1();
      check("R4", {17'b0, out1_data, out1_ee}, {17'b0, 16'd50, 1'b1});
      setch(0, 16'hFFFD); fire1();
      check("R4", {18'b0, out1_data}, {18'b0, 16'hFFFD});
      setch(0, 16'd10); fire1();
      check("R4", {18'b0, out1_data}, {18'b0, 16'hFFFD});
      cur_req = "R9";
      setch(0, 16'hFF9C); ch_ee[5] = 1'b1; ch_ee[6] = 1'b1; step(); ch_ee = '0;
      check("R9", {17'b0, out1_data, out1_ee}, {17'b0, 16'h7FFF, 1'b0});
      init_use = 1'b0; ch_ee[6] = 1'b1; step(); ch_ee[6] = 1'b0;
      check("R9", {17'b0, out1_data, out1_ee}, {17'b0, 16'h7FFF, 1'b0});
      init_use = 1'b1; init_kind = 1'b1; setch(0, 16'h1234);
      ch_ee[6] = 1'b1; step(); ch_ee[6] = 1'b0;
      check("R9", {18'b0, out1_data}, {18'b0, 16'h1234});
      init_use = 1'b0; init_kind = 1'b0;

      cur_req = "R4"; cfg_opcode = 8'h04; sel_a = 5'd0; sel_b = 5'd1;
      setch(0, 16'hFFFB); setch(1, 16'd3); fire1();
      check("R4", {18'b0, out1_data}, {18'b0, 16'd3});

      // R5 compares
      cur_req = "R5"; sel_c = 5'd2; sel_d = 5'd3;
      setch(2, 16'hAAAA); setch(3, 16'h5555);
      for (int op = 8'h10; op <= 8'h15; op++) begin
         for (int p = 0; p < 3; p++) begin
            logic [15:0] av, bv;
            av = (p == 0) ? 16'hFFFE : (p == 1) ? 16'd3 : 16'd4;
            bv = (p == 0) ? 16'd3 : (p == 1) ? 16'd3 : 16'hFFFF;
            cfg_opcode = 8'(op); setch(0, av); setch(1, bv);
            fire1();
            check("R5", {out2_data, out2_ee, 16'b0, out1_ee},
                  {holds(8'(op), av, bv) ? 16'hAAAA : 16'h5555, 1'b1, 16'b0, holds(8'(op), av, bv)});
         end
      end

      // R11 unknown opcode
      cur_req = "R11"; cfg_opcode = 8'h7F; prev = out1_data;
      fire1();
      check("R11", {16'b0, out1_ee, out1_data, out2_ee}, {16'b0, 1'b0, prev, 1'b0});

      // R6 R7 R8 loop
      cur_req = "R6"; cfg_opcode = 8'h20;
      setch(0, 16'd2); setch(1, 16'd7); setch(2, 16'd2); setch(3, 16'd0);
      fire1();
      check("R6", {17'b0, out1_data, out1_ee}, {17'b0, 16'd2, 1'b1});
      ch_ee[5] = 1'b1;
      step();
      check("R6", {17'b0, out1_data, out1_ee}, {17'b0, 16'd4, 1'b1});
      step();
      check("R8", {17'b0, out1_data, out1_ee}, {17'b0, 16'd6, 1'b1});
      ch_ee[5] = 1'b0;
      step();
      check("R7", {16'b0, out1_data, out1_ee, out2_ee}, {16'b0, 16'd6, 1'b0, 1'b1});
      step();
      check("R7", {33'b0, out2_ee}, 34'h0);

      cur_req = "R6";
      setch(0, 16'd0); setch(1, 16'd3); setch(2, 16'd1); setch(3, 16'd2);
      fire1();
      repeat (3) step();
      check("R6", {17'b0, out1_data, out1_ee}, {17'b0, 16'd1, 1'b1});
      repeat (6) step();
      check("R7", {33'b0, out2_ee}, 34'h1);
      fire1();
      check("R8", {17'b0, out1_data, out1_ee}, {17'b0, 16'd0, 1'b1});
      repeat (12) step();

      cur_req = "R7"; setch(0, 16'd5); setch(1, 16'd5);
      fire1();
      check("R7", {32'b0, out1_ee, out2_ee}, {32'b0, 1'b0, 1'b1});
      step();
      cur_req = "R6"; setch(0, 16'hFFFE); setch(1, 16'd1); setch(3, 16'd0);
      fire1();
      repeat (5) step();

      // mixed traffic, reset between opcode changes
      cur_req = "R2";
      for (int blk = 0; blk < 24; blk++) begin
         rst_n = 1'b0; step(); rst_n = 1'b1;
         cfg_opcode = ops[$urandom % 12];
         sel_a = 5'($urandom % 22); sel_b = 5'($urandom % 22);
         sel_c = 5'($urandom % 22); sel_d = 5'($urandom % 4);
         sel_en = 5'($urandom % 15); sel_init = 5'($urandom % 15);
         init_use = 1'($urandom); init_kind = 1'($urandom); init_val = 16'($urandom);
         for (int k = 0; k < NRF; k++) consts[k*16 +: 16] = 16'($urandom % 9) - 16'd4;
         for (int cyc = 0; cyc < 40; cyc++) begin
            for (int k = 0; k < NCH; k++) setch(k, ($urandom % 4 == 0) ? 16'($urandom) : 16'($urandom % 9) - 16'd4);
            ch_ee = NCH'($urandom & $urandom);
            step();
         end
         ch_ee = '0;
      end

      cmp_on = 1'b0;
      summary();
      $finish;
   end

endmodule